// File: doc/BRIEF.md
# Bandwidth-Adaptive Hot-Page Filter Controller

This block decides, one measurement window at a time, whether the hot-page filter in front of a DRAM cache is active. It counts the cycles in which the off-chip memory interface carries a transfer. At the end of each window of programmable length, it compares that busy fraction with a programmable utilization threshold.

When memory traffic is heavy, the filter is switched on, so that only pages already found to be hot are fetched into the DRAM cache. When traffic is light, the filter is switched off, and every page that misses is allocated on demand.

A decision must be seen in two consecutive windows before the filter state follows it. This keeps a single noisy window from flipping the allocation policy. The busy count of the most recent completed window is presented as a utilization readout.

Top module: `bw_policy_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `filter_en` is 1 and `util_busy` is 0 until the first window completes.
- R2: A window covers `win_len` consecutive cycles (a `win_len` of 0 or 1 gives one-cycle windows). In the cycle after the last cycle of a window, `util_busy` holds the number of cycles in that window in which `mem_xfer` was 1.
- R3: A completed window counts as heavy when busy_cycles * 2^FRAC_W > `util_thresh` * `win_len`. Here `util_thresh` is an unsigned fraction of peak bandwidth with FRAC_W fractional bits, so 77 means about 0.30 when FRAC_W is 8.
- R4: A window whose busy_cycles * 2^FRAC_W equals `util_thresh` * `win_len` exactly counts as light, not heavy.
- R5: At the end of a window, `filter_en` takes the value 1 for heavy or 0 for light only when this window and the window before it gave the same decision. Before the first window, the "previous" decision is heavy.
- R6: `filter_en` and `util_busy` change only in the cycle that follows the last cycle of a window.
- R7: A single window whose decision differs from both its predecessor and the current `filter_en` leaves `filter_en` unchanged.
- R8: A window in which every cycle is busy reports `util_busy` equal to `win_len`, up to the largest `win_len` that CNT_W can hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_xfer | input | 1 | 1 in each cycle the memory interface moves data |
| win_len | input | CNT_W | Window length in cycles |
| util_thresh | input | FRAC_W | Utilization threshold, fraction with FRAC_W fractional bits |
| filter_en | output | 1 | 1: only hot pages are allocated; 0: all misses are allocated |
| util_busy | output | CNT_W | Busy cycles counted in the last completed window |

## Verification
The bench builds the block with CNT_W = 8 and FRAC_W = 8. With these values, a window of 255 cycles, the longest the counters hold, can be driven fully busy in a few hundred cycles, which reaches the full-scale readout and the widest product in the threshold comparison.

Most windows are 20 cycles long. At that length a threshold of 77 puts the heavy/light boundary between 6 and 7 busy cycles, and a threshold of 128 makes 10 busy cycles an exact tie. Short 4-cycle and 1-cycle windows check that a change of `win_len` takes effect at once.

// File: rtl/bw_policy_ctrl.sv
module bw_policy_ctrl #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_xfer,
  input  logic [CNT_W-1:0]  win_len,
  input  logic [FRAC_W-1:0] util_thresh,
  output logic              filter_en,
  output logic [CNT_W-1:0]  util_busy
);
  localparam int PW = CNT_W + FRAC_W;

  logic [CNT_W-1:0] cyc, busy_cnt, busy_total;
  logic [PW-1:0]    busy_scaled, thr_scaled;
  logic             win_last, heavy, prev_heavy;

  assign win_last    = (win_len <= CNT_W'(1)) || (cyc >= win_len - CNT_W'(1));
  assign busy_total  = busy_cnt + CNT_W'(mem_xfer);
  assign busy_scaled = {busy_total, {FRAC_W{1'b0}}};
  assign thr_scaled  = PW'(util_thresh) * PW'(win_len);
  assign heavy       = busy_scaled > thr_scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc        <= '0;
      busy_cnt   <= '0;
      util_busy  <= '0;
      filter_en  <= 1'b1;
      prev_heavy <= 1'b1;
    end else if (win_last) begin
      cyc        <= '0;
      busy_cnt   <= '0;
      util_busy  <= busy_total;
      prev_heavy <= heavy;
      if (heavy == prev_heavy) filter_en <= heavy;
    end else begin
      cyc      <= cyc + CNT_W'(1);
      busy_cnt <= busy_total;
    end
  end
endmodule

// File: rtl/bw_policy_chk.sv
module bw_policy_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_xfer,
  input logic             win_last,
  input logic [CNT_W-1:0] cyc,
  input logic [CNT_W-1:0] busy_cnt,
  input logic             filter_en,
  input logic [CNT_W-1:0] util_busy
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (filter_en && util_busy == '0));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(filter_en));

  // R6
  readout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(util_busy));

  // R2
  idle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && busy_cnt == '0 && !mem_xfer) |=> util_busy == '0);

  // R8
  full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && mem_xfer && busy_cnt == cyc) |=> util_busy == $past(cyc) + CNT_W'(1));
endmodule

bind bw_policy_ctrl bw_policy_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_xfer(mem_xfer), .win_last(win_last),
  .cyc(cyc), .busy_cnt(busy_cnt), .filter_en(filter_en), .util_busy(util_busy)
);

// File: tb/tb_bw_policy_ctrl.sv
module tb_bw_policy_ctrl;
  localparam int CNT_W = 8;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_xfer = 1'b0;
  logic [CNT_W-1:0] win_len = 8'd20;
  logic [FRAC_W-1:0] util_thresh = 8'd77;
  logic filter_en;
  logic [CNT_W-1:0] util_busy;

  bw_policy_ctrl #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .mem_xfer(mem_xfer), .win_len(win_len),
    .util_thresh(util_thresh), .filter_en(filter_en), .util_busy(util_busy)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    busy;
    bit    en;
    string busy_req;
    string en_req;
  } exp_t;

  exp_t q[$];
  event win_done;
  int tests = 0, fails = 0;
  bit m_en = 1'b1, m_prev = 1'b1;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_window(input int len, input int thr, input int nb,
                            input string busy_req, input string en_req);
    exp_t e;
    bit hv;
    bit en0 = filter_en;
    int b0 = int'(util_busy);
    bit mid_ok = 1'b1;
    win_len = CNT_W'(len);
    util_thresh = FRAC_W'(thr);
    for (int i = 0; i < len; i++) begin
      mem_xfer = (i < nb);
      @(negedge clk);
      if (i < len - 1 && (filter_en != en0 || int'(util_busy) != b0)) mid_ok = 1'b0;
    end
    mem_xfer = 1'b0;
    check(mid_ok, "R6", "outputs held inside window", int'(mid_ok), 1);
    hv = (nb * 256) > (thr * len);
    if (hv == m_prev) m_en = hv;
    m_prev = hv;
    e.busy = nb; e.en = m_en; e.busy_req = busy_req; e.en_req = en_req;
    q.push_back(e);
    -> win_done;
    #1;
  endtask

  initial begin
    exp_t e;
    forever begin
      @(win_done);
      while (q.size() > 0) begin
        e = q.pop_front();
        check(int'(util_busy) == e.busy, e.busy_req, "util_busy", int'(util_busy), e.busy);
        check(filter_en == e.en, e.en_req, "filter_en", int'(filter_en), int'(e.en));
      end
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(filter_en == 1'b1, "R1", "filter_en in reset", int'(filter_en), 1);
    check(util_busy == '0, "R1", "util_busy in reset", int'(util_busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(filter_en == 1'b1, "R1", "filter_en before first window", int'(filter_en), 1);
    check(util_busy == '0, "R1", "util_busy before first window", int'(util_busy), 0);
    // Finish the first window that started at reset release (15 more idle cycles)
    repeat (15) @(negedge clk);
    m_prev = 1'b0;
    check(filter_en == 1'b1, "R7", "filter_en after one light window", int'(filter_en), 1);
    // threshold 77, window 20: heavy from 7 busy cycles
    run_window(20, 77, 15, "R2", "R5");  // heavy after light: hold
    run_window(20, 77, 15, "R2", "R3");  // heavy twice: stays on
    run_window(20, 77, 2,  "R2", "R7");  // single light: hold
    run_window(20, 77, 15, "R2", "R7");
    run_window(20, 77, 6,  "R2", "R3");  // 1536 vs 1540 light
    run_window(20, 77, 6,  "R2", "R5");  // second light: off
    run_window(20, 77, 7,  "R2", "R7");  // single heavy: stays off
    run_window(20, 77, 0,  "R2", "R5");
    run_window(20, 128, 10, "R2", "R4"); // exact tie is light
    run_window(20, 128, 10, "R2", "R4");
    run_window(20, 128, 11, "R2", "R3");
    run_window(20, 128, 11, "R2", "R5"); // on again
    run_window(255, 255, 255, "R8", "R3");
    run_window(4, 77, 0, "R2", "R5");
    run_window(4, 77, 1, "R2", "R5");    // 256 < 308: light twice, off
    run_window(4, 77, 2, "R2", "R7");
    run_window(1, 77, 1, "R2", "R5");
    run_window(1, 77, 0, "R2", "R7");
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule